// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Zero-Blanking Chain

This block turns a row of 4-bit BCD digits into active-low seven-segment drive patterns, one pattern per digit. Each digit is handled by its own decoding cell. A cell blanks its digit when the digit is zero and its neighbour reports that it also blanked a zero. The cell then reports the same to the next neighbour. Chaining cells this way hides zeros that carry no information on a multi-digit display.

The top level places N cells side by side. It takes a binary-point position that says how many of the rightmost digits are fractional. Integer digits run their chain from the most significant digit downward, so leading zeros go dark. Fractional digits run their chain from the rightmost digit toward the point, so trailing zeros go dark. The digit just left of the point is never blanked by the chain, so a zero value still reads "0".

A lamp-test input and a per-digit force-blank input let the surrounding logic override the decode. The block is purely combinational.

Top module: `bcd_display_decoder`

## Requirements
- R1: When `lamp_test` is high, every segment of every digit is driven low (lit), whatever any other input is.
- R2: When `force_blank[i]` is high and `lamp_test` is low, all seven segments of digit i are driven high (dark). Force-blank has no effect on `rbo[i]`.
- R3: Digit i (digit 0 is the rightmost) appears on `seg_n[7*i+6:7*i]` in the order {g,f,e,d,c,b,a}, with segment a at the lowest bit. A 0 lights a segment.
- R4: A non-blanked code 0 to 9 lights these segments: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg.
- R5: A code from 10 to 15 darkens its digit, drives its `rbo` low and is never treated as zero by either chain.
- R6: An integer digit other than the units digit is dark when it is zero and every more significant digit is zero.
- R7: A fractional digit is dark when it is zero and every less significant digit is zero.
- R8: The units digit, at index `point_pos`, is never darkened by the chain. A `point_pos` of N or more makes every digit fractional.
- R9: `rbo[i]` is high exactly when digit i received a chain blank request, its code is 0, and `lamp_test` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digits | input | 4*N | BCD codes; digit i in bits [4*i+3:4*i], digit 0 rightmost |
| point_pos | input | $clog2(N+1) | Number of fractional digits at the right end |
| lamp_test | input | 1 | Light every segment |
| force_blank | input | N | Per-digit unconditional blank |
| seg_n | output | 7*N | Active-low segments, 7 bits per digit, {g..a} |
| rbo | output | N | Per-digit ripple-blank status, high when the cell blanked a zero |

## Verification
The hardest cases to reach are long chains of zeros that stop exactly at the units digit or at the binary point. Random digits rarely produce these. The stimulus therefore walks every decimal value of four digits under every point position, so each run of zeros meets each boundary. A second phase adds invalid codes, force-blank, lamp test and out-of-range point positions. In that phase zeros are weighted heavily so that chains still form around the override inputs.

// File: rtl/bcdseg_pkg.sv
package bcdseg_pkg;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  // Active-high lit pattern, bit order {g,f,e,d,c,b,a}.
  function automatic seg_t glyph_lit(input bcd_t code);
    seg_t lit;
    case (code)
      4'd0:    lit = 7'b0111111;
      4'd1:    lit = 7'b0000110;
      4'd2:    lit = 7'b1011011;
      4'd3:    lit = 7'b1001111;
      4'd4:    lit = 7'b1100110;
      4'd5:    lit = 7'b1101101;
      4'd6:    lit = 7'b1111101;
      4'd7:    lit = 7'b0000111;
      4'd8:    lit = 7'b1111111;
      4'd9:    lit = 7'b1101111;
      default: lit = 7'b0000000;
    endcase
    return lit;
  endfunction
endpackage

// File: rtl/bcdseg_cell.sv
module bcdseg_cell
  import bcdseg_pkg::*;
(
  input  bcd_t code,
  input  logic rbi,
  input  logic lamp_test,
  input  logic force_blank,
  output seg_t seg_n,
  output logic rbo
);
  logic is_zero;
  logic is_valid;
  logic rip_blank;
  seg_t lit;

  always_comb begin
    is_zero   = (code == 4'd0);
    is_valid  = (code < 4'd10);
    rip_blank = rbi & is_zero;
    rbo       = rip_blank & ~lamp_test;
    if (lamp_test) begin
      lit = '1;
    end else if (force_blank || rip_blank || !is_valid) begin
      lit = '0;
    end else begin
      lit = glyph_lit(code);
    end
    seg_n = ~lit;
  end
endmodule

// File: rtl/bcdseg_chain.sv
module bcdseg_chain #(
  parameter int N  = 4,
  parameter int PW = $clog2(N + 1)
) (
  input  logic [4*N-1:0] digits,
  input  logic [PW-1:0]  point_pos,
  input  logic           lamp_test,
  output logic [N-1:0]   rbi
);
  int   p;
  logic lead_c;
  logic trail_c;

  always_comb begin
    p       = (int'(point_pos) > N) ? N : int'(point_pos);
    rbi     = '0;
    lead_c  = 1'b1;
    trail_c = 1'b1;
    // integer part: from the most significant digit down to the units
    for (int i = N - 1; i >= 0; i--) begin
      if (i >= p) begin
        rbi[i] = (i == p) ? 1'b0 : lead_c;
        lead_c = rbi[i] & (digits[4*i +: 4] == 4'd0) & ~lamp_test;
      end
    end
    // fractional part: from the rightmost digit up to the point
    for (int i = 0; i < N; i++) begin
      if (i < p) begin
        rbi[i]  = trail_c;
        trail_c = rbi[i] & (digits[4*i +: 4] == 4'd0) & ~lamp_test;
      end
    end
  end
endmodule

// File: rtl/bcd_display_decoder.sv
module bcd_display_decoder #(
  parameter int N  = 4,
  parameter int PW = $clog2(N + 1)
) (
  input  logic [4*N-1:0] digits,
  input  logic [PW-1:0]  point_pos,
  input  logic           lamp_test,
  input  logic [N-1:0]   force_blank,
  output logic [7*N-1:0] seg_n,
  output logic [N-1:0]   rbo
);
  logic [N-1:0] rbi;

  bcdseg_chain #(.N(N), .PW(PW)) u_chain (
    .digits    (digits),
    .point_pos (point_pos),
    .lamp_test (lamp_test),
    .rbi       (rbi)
  );

  for (genvar g = 0; g < N; g++) begin : g_cell
    bcdseg_cell u_cell (
      .code        (digits[4*g +: 4]),
      .rbi         (rbi[g]),
      .lamp_test   (lamp_test),
      .force_blank (force_blank[g]),
      .seg_n       (seg_n[7*g +: 7]),
      .rbo         (rbo[g])
    );
  end
endmodule

// File: rtl/bcdseg_chk.sv
module bcdseg_chk #(
  parameter int N  = 4,
  parameter int PW = $clog2(N + 1)
) (
  input logic [4*N-1:0] digits,
  input logic [PW-1:0]  point_pos,
  input logic           lamp_test,
  input logic [N-1:0]   force_blank,
  input logic [7*N-1:0] seg_n,
  input logic [N-1:0]   rbo
);
  int p;
  always_comb begin
    p = (int'(point_pos) > N) ? N : int'(point_pos);
    a_r1_lamp_lights_all: assert (!lamp_test || seg_n == '0);
    for (int i = 0; i < N; i++) begin
      a_r2_force_darkens: assert (lamp_test || !force_blank[i] || seg_n[7*i +: 7] == 7'h7f);
      a_r5_invalid_no_rbo: assert (digits[4*i +: 4] < 4'd10 || (!rbo[i] && seg_n[7*i +: 7] == 7'h7f) || lamp_test);
      a_r9_rbo_only_zero: assert (!rbo[i] || (digits[4*i +: 4] == 4'd0 && !lamp_test && seg_n[7*i +: 7] == 7'h7f));
      a_r8_units_no_rbo: assert (i != p || !rbo[i]);
      if (i > p && i < N - 1) begin
        a_r6_lead_link: assert (rbo[i] == (rbo[i+1] & (digits[4*i +: 4] == 4'd0) & ~lamp_test));
      end
      if (i > 0 && i < p) begin
        a_r7_trail_link: assert (rbo[i] == (rbo[i-1] & (digits[4*i +: 4] == 4'd0) & ~lamp_test));
      end
    end
  end
endmodule

bind bcd_display_decoder bcdseg_chk #(.N(N), .PW(PW)) u_chk (
  .digits      (digits),
  .point_pos   (point_pos),
  .lamp_test   (lamp_test),
  .force_blank (force_blank),
  .seg_n       (seg_n),
  .rbo         (rbo)
);

// File: tb/bcd_display_decoder_test.sv
`timescale 1ns/1ps
module bcd_display_decoder_test;
  localparam int N  = 4;
  localparam int PW = $clog2(N + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4*N-1:0] digits;
  logic [PW-1:0]  point_pos;
  logic           lamp_test;
  logic [N-1:0]   force_blank;
  logic [7*N-1:0] seg_n;
  logic [N-1:0]   rbo;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  bcd_display_decoder #(.N(N), .PW(PW)) uut (.*);

  // R4 lit patterns written as strings of segment letters
  function automatic logic [6:0] pattern(input int code);
    string s;
    logic [6:0] v;
    case (code)
      0: s = "abcdef";  1: s = "bc";     2: s = "abdeg";
      3: s = "abcdg";   4: s = "bcfg";   5: s = "acdfg";
      6: s = "acdefg";  7: s = "abc";    8: s = "abcdefg";
      default: s = "abcdfg";
    endcase
    v = '0;
    for (int k = 0; k < s.len(); k++) v[s[k] - "a"] = 1'b1;
    return v;
  endfunction

  task automatic check_now();
    int p;
    bit run;
    bit rip[N];
    for (int i = 0; i < N; i++) rip[i] = 0;
    p = (int'(point_pos) > N) ? N : int'(point_pos);
    run = 1;
    for (int i = N - 1; i >= p; i--) begin
      int d = int'(digits[4*i +: 4]);
      if (i == p) run = 0;
      rip[i] = run && d == 0;
      run = rip[i] && !lamp_test;
    end
    run = 1;
    for (int i = 0; i < p; i++) begin
      int d = int'(digits[4*i +: 4]);
      rip[i] = run && d == 0;
      run = rip[i] && !lamp_test;
    end
    for (int i = 0; i < N; i++) begin
      int d = int'(digits[4*i +: 4]);
      logic [6:0] exp_seg;
      logic exp_rbo;
      string tag;
      if (lamp_test) begin exp_seg = 7'h00; tag = "R1"; end
      else if (force_blank[i]) begin exp_seg = 7'h7f; tag = "R2"; end
      else if (d > 9) begin exp_seg = 7'h7f; tag = "R5"; end
      else if (rip[i]) begin exp_seg = 7'h7f; tag = (i >= p) ? "R6" : "R7"; end
      else begin exp_seg = ~pattern(d); tag = (i == p) ? "R8" : "R4"; end
      exp_rbo = rip[i] && !lamp_test;
      n_cmp++;
      // R3: slice of digit i in seg_n
      if (seg_n[7*i +: 7] !== exp_seg) begin
        n_bad++;
        $display("FAIL %s digit %0d seg_n actual %b expected %b (digits=%h p=%0d lt=%b fb=%b)",
                 tag, i, seg_n[7*i +: 7], exp_seg, digits, point_pos, lamp_test, force_blank);
      end
      n_cmp++;
      if (rbo[i] !== exp_rbo) begin
        n_bad++;
        $display("FAIL R9 digit %0d rbo actual %b expected %b (digits=%h p=%0d lt=%b)",
                 i, rbo[i], exp_rbo, digits, point_pos, lamp_test);
      end
    end
  endtask

  task automatic apply(input logic [4*N-1:0] d, input int p, input bit lt, input logic [N-1:0] fb);
    @(negedge clk);
    digits = d; point_pos = PW'(p); lamp_test = lt; force_blank = fb;
    @(posedge clk);
    #1;
    check_now();
  endtask

  initial begin
    digits = '0; point_pos = '0; lamp_test = 1'b0; force_blank = '0;
    // idle state: all zeros shows a single "0" on the units digit (R8)
    apply('0, 0, 0, '0);
    // R3/R4 pattern spot check: 8.6 -> units shows 8
    apply(16'h0086, 1, 0, '0);
    // exhaustive decimal values under every point position (R4, R6, R7, R8)
    for (int v = 0; v < 10000; v++) begin
      logic [15:0] bcd;
      bcd = {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
      for (int p = 0; p <= N; p++) apply(bcd, p, 0, '0);
    end
    // overrides, invalid codes (R5), lamp test (R1), force-blank (R2), point clamp (R8)
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] bcd;
      logic [N-1:0] fb;
      for (int i = 0; i < N; i++) begin
        bcd[4*i +: 4] = ($urandom % 2) ? 4'd0 : 4'($urandom % 16);
        fb[i] = ($urandom % 8) == 0;
      end
      apply(bcd, int'($urandom % 8), ($urandom % 16) == 0, fb);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule